// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product. It uses a single N-bit adder and one carry flip-flop, and processes one multiplier bit per clock. A one-cycle `start` pulse captures both operands and clears a double-width accumulator. On each of the next N clocks the lowest remaining multiplier bit decides whether the multiplicand is added into the upper half of the accumulator. The carry out of that addition then enters at the top while the whole accumulator rotates right by one place.

The block suits datapaths where an occasional wide product is needed and area matters more than latency. When the last iteration ends, `busy` drops and `done` pulses for one cycle. `product` then holds the result until software-independent control logic issues the next accepted `start`. A `start` that arrives while a multiplication is in progress is ignored. A `start` in the same cycle as `done` is accepted, because `busy` is already low then. The adder can be built either as an explicit ripple chain or as a plain behavioural sum; a parameter selects which.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled while `busy` is 0 captures both operands, and `busy` is 1 from the next cycle on.
- R3: The value in `product` while `done` is 1 equals the unsigned product multiplicand × multiplier over the full 2N bits. This holds for zero, one and all-ones operands (for N=8, 0xFF × 0xFF = 0xFE01; 0x06 × 0x0A = 0x003C).
- R4: `done` is 1 for exactly one cycle, N clock edges after the edge that accepted `start`. `busy` falls at that same edge.
- R5: A `start` sampled while `busy` is 1 is ignored. The running multiplication finishes on time with the result for the operands captured at the accepted start.
- R6: One cycle after an accepted `start`, `product` reads 0. After `done`, `product` keeps its value until the next accepted `start`.
- R7: While `busy` is 1, `product` shows the running accumulator. After the first iteration it equals multiplicand << (N−1) if bit 0 of the multiplier is 1, and 0 if that bit is 0. An iteration whose multiplier bit is 0 leaves the top accumulator bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication; acted on only when idle |
| multiplicand | input | WIDTH | Unsigned multiplicand, captured at an accepted start |
| multiplier | input | WIDTH | Unsigned multiplier, captured at an accepted start |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Accumulator: the running value while busy, the final product afterwards |

## Verification
The hardest situations to reach from the ports are a `start` that lands in the middle of a run and a `start` that coincides with the `done` pulse. The first must leave the run untouched. The second must be accepted while the previous result is still being checked. The driver therefore raises `start` with inverted operands two iterations into some runs, and issues other runs in the very cycle `done` is seen. The scoreboard then confirms that each `done` pops exactly the expected product, in order. The all-ones operand pair drives a carry out of the upper-half adder on almost every iteration. This exercises the path where the carry must enter at the top of the rotate.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

   // Selects how the upper-half adder is built
   typedef enum logic [0:0] {
      ADD_BEHAVIOURAL = 1'b0,
      ADD_RIPPLE      = 1'b1
   } add_style_e;

   // Width of a down-counter able to hold the value n
   function automatic int unsigned count_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl #(
   parameter int unsigned WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int unsigned CW = shift_add_mul_pkg::count_bits(WIDTH);

   logic [CW-1:0] iter_left;
   logic          busy_q;
   logic          done_q;

   if (WIDTH < 2) begin : g_bad_width
      $error("sam_ctrl: WIDTH must be at least 2");
   end

   assign load = start & ~busy_q;
   assign step = busy_q;
   assign busy = busy_q;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         iter_left <= '0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            busy_q    <= 1'b1;
            iter_left <= CW'(WIDTH);
         end else if (busy_q) begin
            iter_left <= iter_left - CW'(1);
            if (iter_left == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (busy && iter_left == CW'(WIDTH))) else $error("load did not arm counter"); // R2
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (iter_left == $past(iter_left) - CW'(1))) else $error("counter disturbed while busy"); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R4
   AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done) else $error("busy fell without done"); // R4

endmodule

// File: rtl/sam_upper_add.sv
module sam_upper_add #(
   parameter int unsigned                   WIDTH     = 8,
   parameter shift_add_mul_pkg::add_style_e ADD_STYLE = shift_add_mul_pkg::ADD_RIPPLE
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);
   if (ADD_STYLE == shift_add_mul_pkg::ADD_RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]     = op_a[i] ^ op_b[i] ^ chain[i];
         assign chain[i+1] = (op_a[i] & op_b[i]) | (chain[i] & (op_a[i] ^ op_b[i]));
      end
      assign carry_out = chain[WIDTH];
   end else begin : g_behavioural
      assign {carry_out, sum} = {1'b0, op_a} + {1'b0, op_b};
   end

endmodule

// File: rtl/sam_acc.sv
module sam_acc #(
   parameter int unsigned                   WIDTH     = 8,
   parameter shift_add_mul_pkg::add_style_e ADD_STYLE = shift_add_mul_pkg::ADD_RIPPLE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [WIDTH-1:0]   mcand_in,
   input  logic [WIDTH-1:0]   mplier_in,
   output logic [2*WIDTH-1:0] acc
);
   localparam int unsigned AW = 2 * WIDTH;

   logic [AW-1:0]    acc_q;
   logic [WIDTH-1:0] mcand_q;
   logic [WIDTH-1:0] mplier_q;
   logic             cond_bit;
   logic [WIDTH-1:0] addend;
   logic [WIDTH-1:0] upper_sum;
   logic             carry_bit;
   logic [AW-1:0]    acc_next;

   assign cond_bit = mplier_q[0];
   assign addend   = cond_bit ? mcand_q : '0;

   sam_upper_add #(
      .WIDTH     (WIDTH),
      .ADD_STYLE (ADD_STYLE)
   ) u_add (
      .op_a      (acc_q[AW-1:WIDTH]),
      .op_b      (addend),
      .sum       (upper_sum),
      .carry_out (carry_bit)
   );

   // rotate right through the carry: carry enters at the top, bit 0 drops out
   assign acc_next = {carry_bit, upper_sum, acc_q[WIDTH-1:1]};
   assign acc      = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
      end else if (load) begin
         acc_q    <= '0;
         mcand_q  <= mcand_in;
         mplier_q <= mplier_in;
      end else if (step) begin
         acc_q    <= acc_next;
         mplier_q <= mplier_q >> 1;
      end
   end

   AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (acc_q == '0)) else $error("accumulator not cleared"); // R6
   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(acc_q)) else $error("accumulator moved while idle"); // R6
   AST_ZERO_BIT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !cond_bit) |=> !acc_q[AW-1]) else $error("carry entered on zero bit"); // R7

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
   parameter int unsigned                   WIDTH     = 8,
   parameter shift_add_mul_pkg::add_style_e ADD_STYLE = shift_add_mul_pkg::ADD_RIPPLE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   multiplicand,
   input  logic [WIDTH-1:0]   multiplier,
   output logic               busy,
   output logic               done,
   output logic [2*WIDTH-1:0] product
);
   logic load;
   logic step;

   sam_ctrl #(
      .WIDTH (WIDTH)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   sam_acc #(
      .WIDTH     (WIDTH),
      .ADD_STYLE (ADD_STYLE)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .step      (step),
      .mcand_in  (multiplicand),
      .mplier_in (multiplier),
      .acc       (product)
   );

   AST_PRODUCT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product)) else $error("product changed while idle"); // R6

endmodule

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   a = '0;
   logic [W-1:0]   b = '0;
   logic           busy;
   logic           done;
   logic [2*W-1:0] product;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int start_cyc = 0;
   logic [2*W-1:0] exp_q[$];

   shift_add_mul #(.WIDTH(W)) u_shift_add_mul (
      .clk(clk), .rst_n(rst_n), .start(start),
      .multiplicand(a), .multiplier(b),
      .busy(busy), .done(done), .product(product)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   // monitor: every done pops the oldest expected product (R3)
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected done", 32'(product), 32'hFFFF_FFFF);
         end else begin
            logic [2*W-1:0] e;
            e = exp_q.pop_front();
            check(product == e, "R3 product", 32'(product), 32'(e));
         end
      end
   end

   // driver: one multiplication; optional mid-run start, optional start in done cycle
   task automatic run_mul(input logic [W-1:0] av, input logic [W-1:0] bv,
                          input bit poke, input bit in_done_cycle);
      logic [2*W-1:0] first_iter;
      if (!in_done_cycle) @(negedge clk);
      a = av; b = bv; start = 1'b1;
      exp_q.push_back((2*W)'(av) * (2*W)'(bv));
      start_cyc = cyc;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
      check(product == '0, "R6 cleared at start", 32'(product), 32'd0);
      @(negedge clk);
      first_iter = bv[0] ? ((2*W)'(av) << (W-1)) : '0;
      check(product == first_iter, "R7 first iteration", 32'(product), 32'(first_iter));
      if (poke) begin
         start = 1'b1; a = ~av; b = ~bv;
         @(negedge clk);
         start = 1'b0;
         check(busy == 1'b1, "R5 still busy", 32'(busy), 32'd1);
      end
      while (!done) @(negedge clk);
      check(cyc - start_cyc == W + 1, "R4 done latency", 32'(cyc - start_cyc), 32'(W + 1));
      check(busy == 1'b0, "R4 busy low with done", 32'(busy), 32'd0);
   endtask

   task automatic hold_check(input int n);
      logic [2*W-1:0] p;
      p = product;
      repeat (n) begin
         @(negedge clk);
         check(product == p, "R6 product held", 32'(product), 32'(p));
         check(done == 1'b0, "R4 done single cycle", 32'(done), 32'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = 32'h1234_5678;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy reset", 32'(busy), 32'd0);
      check(done == 1'b0, "R1 done reset", 32'(done), 32'd0);
      check(product == '0, "R1 product reset", 32'(product), 32'd0);
      rst_n = 1'b1;

      run_mul(8'h06, 8'h0A, 1'b0, 1'b0); hold_check(3);
      run_mul(8'hFF, 8'hFF, 1'b0, 1'b0); hold_check(2);
      run_mul(8'h00, 8'h5A, 1'b1, 1'b0); hold_check(2);
      run_mul(8'h80, 8'h02, 1'b1, 1'b0);
      run_mul(8'h01, 8'hFF, 1'b0, 1'b1);          // start in done cycle
      run_mul(8'hFF, 8'h01, 1'b1, 1'b1);
      hold_check(4);
      for (int i = 0; i < 16; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         run_mul(seed[23:16], seed[15:8], seed[0], seed[1]);
      end
      hold_check(2);
      check(exp_q.size() == 0, "R3 all results seen", 32'(exp_q.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule